// File: doc/BRIEF.md
# Consecutive-ones serial detector

The block watches a serial bit stream, taking one bit per clock on `din`. It raises `hit` while the current bit is the third or a later bit in an unbroken run of ones. A zero ends the run at once, and counting starts again with the next one. Typical uses are spotting a sustained high level on a line, or marking a run-length threshold in a bit stream.

The machine keeps three states in a two-bit register: idle (last bit was zero, or just reset), one-seen, and run (two or more ones seen). The cases "two ones" and "three or more ones" act the same on every future input, so they share one state. The output is Mealy: `hit` is the high state bit ANDed with the present input. It therefore rises in the same cycle as the third one, with no register on the way. The fourth encoding is never entered in normal use. If it is ever entered, it falls back to idle on the next clock, so the machine is self-starting.

Top module: `ones_run_detector`

## Requirements
- R1: `rst` is synchronous and active high. A clock edge with `rst` high puts the machine in idle (encoding 2'b00) whatever `din` is, so a single 1 presented after reset gives `hit`=0.
- R2: Whenever `din` is 0, `hit` is 0 in that cycle.
- R3: The first and the second 1 of a run give `hit`=0.
- R4: The third consecutive 1 gives `hit`=1 in the same cycle in which that bit is presented on `din`.
- R5: Every further 1 of the same run keeps `hit`=1.
- R6: A 0 clears the run: after 1,1,0 the next two 1s give `hit`=0 and the third gives `hit`=1.
- R7: A reset edge in the middle of a run discards the ones seen before it. The run restarts at the first bit after reset.
- R8: The state encodings are idle 2'b00, one-seen 2'b01 and run 2'b10. The unused encoding 2'b11 moves to idle on the next clock regardless of `din`. From any state, one 0 followed by a single 1 gives `hit`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit for this cycle |
| hit | output | 1 | High while the current bit is the third or later 1 of a run |

## Verification
A wrong state register shows at `hit` by the next bit of a run at the latest. A machine stuck in idle or one-seen never raises `hit` on a third 1. A machine that leaves the run state early drops `hit` on the fourth 1. A machine that keeps counting across a 0 or a reset raises `hit` on the first or second 1 of a new run. Because the output is Mealy, each of these errors appears in the same cycle as the offending input bit, not one cycle later.

// File: rtl/ones_run_detector.sv
`timescale 1ns/1ps
module ones_run_detector (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);

  typedef enum logic [1:0] {
    S_IDLE = 2'b00,
    S_ONE  = 2'b01,
    S_RUN  = 2'b10,
    S_BAD  = 2'b11
  } state_t;

  state_t state;
  state_t state_nx;

  always_comb begin
    case (state)
      S_IDLE:  state_nx = din ? S_ONE : S_IDLE;
      S_ONE:   state_nx = din ? S_RUN : S_IDLE;
      S_RUN:   state_nx = din ? S_RUN : S_IDLE;
      S_BAD:   state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= state_nx;
  end

  assign hit = din & state[1];

endmodule

// File: rtl/ones_run_detector_chk.sv
`timescale 1ns/1ps
module ones_run_detector_chk (
  input logic       clk,
  input logic       rst,
  input logic       din,
  input logic       hit,
  input logic [1:0] st
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> st == 2'b00);

  p_zero_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !din |-> !hit);

  p_first_one_r3: assert property (@(posedge clk) disable iff (rst)
    (din && !$past(din)) |-> !hit);

  p_second_one_r3: assert property (@(posedge clk) disable iff (rst)
    (din && $past(din) && !$past(din, 2)) |-> !hit);

  p_third_one_r4: assert property (@(posedge clk) disable iff (rst)
    (din && $past(din) && $past(din, 2) && !$past(rst) && !$past(rst, 2)) |-> hit);

  p_unused_exit_r8: assert property (@(posedge clk) disable iff (rst)
    st == 2'b11 |=> st == 2'b00);

endmodule

bind ones_run_detector ones_run_detector_chk u_chk (
  .clk (clk),
  .rst (rst),
  .din (din),
  .hit (hit),
  .st  (state)
);

// File: tb/sim_ones_run_detector.sv
`timescale 1ns/1ps
module sim_ones_run_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;
  logic done = 1'b0;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ones_run_detector u0 (.clk(clk), .rst(rst), .din(din), .hit(hit));

  localparam int NV = 24;
  localparam logic [1:0] VEC [0:NV-1] = '{
    2'b10, 2'b00, 2'b10, 2'b10, 2'b00, 2'b10, 2'b10, 2'b11,
    2'b11, 2'b00, 2'b10, 2'b10, 2'b11, 2'b00, 2'b00, 2'b10,
    2'b10, 2'b11, 2'b11, 2'b11, 2'b00, 2'b10, 2'b00, 2'b00
  };

  task automatic check(input logic exp, input string tag);
    checks++;
    if (hit !== exp) begin
      failures++;
      $display("FAIL %s: hit=%b expected=%b at %0t", tag, hit, exp, $time);
    end
  endtask

  task automatic step(input logic d, input logic r, input bit chk, input logic exp, input string tag);
    @(negedge clk);
    din = d;
    rst = r;
    #1;
    if (chk) check(exp, tag);
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(0, 1, 0, 0, "R1");
    step(0, 1, 0, 0, "R1");
    step(0, 1, 1, 0, "R1 reset with din=0");
    step(1, 0, 1, 0, "R1 lone one after reset");
    step(0, 0, 1, 0, "R2");

    for (int i = 0; i < NV; i++) begin
      string tag;
      if (!VEC[i][1])     tag = "R2 zero bit";
      else if (VEC[i][0]) tag = "R4/R5 run bit";
      else                tag = "R3/R6 early one";
      step(VEC[i][1], 0, 1, VEC[i][0], tag);
    end

    step(1, 0, 1, 0, "R3");
    step(1, 0, 1, 0, "R3");
    step(1, 1, 0, 0, "R7");
    step(1, 0, 1, 0, "R7 first after reset");
    step(1, 0, 1, 0, "R7 second after reset");
    step(1, 0, 1, 1, "R7 third after reset");

    step(1, 1, 0, 0, "R1");
    step(1, 1, 0, 0, "R1");
    step(1, 0, 1, 0, "R1 ones during reset ignored");
    step(1, 0, 1, 0, "R1 second");
    step(1, 0, 1, 1, "R4 third");
    step(1, 0, 1, 1, "R5 fourth");
    step(1, 0, 1, 1, "R5 fifth");
    step(0, 0, 1, 0, "R8 zero from run");
    step(1, 0, 1, 0, "R8 idle reached");
    step(1, 0, 1, 0, "R6 second");
    step(0, 0, 1, 0, "R6 break");
    step(1, 0, 1, 0, "R6 restart");
    step(1, 0, 1, 0, "R6 restart second");
    step(1, 0, 1, 1, "R6 restart third");
    step(0, 0, 1, 0, "R2 end");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule